// File: doc/BRIEF.md
# Debounced Trigger Priority Interrupt Controller

This block watches four active-low trigger pins, filters contact bounce on each one, and turns every accepted rising or falling transition into an interrupt request. Each pin has two enable bits, one per edge direction, held in two 8-bit enable words. A transition whose enable bit is clear is dropped. A transition whose enable bit is set is latched as pending. A power-on start request and a software jump request join the same pending set.

A fixed-priority arbiter presents the most urgent pending source as a 6-bit vector number, together with a one-cycle valid pulse. The sequencer that consumes the vector pulses `ack` to retire it. A higher-priority event that arrives while a vector is being served produces a new pulse at once, without waiting for the acknowledge. This lets an enabled edge cut into whatever is running.

The filter length is counted in pulses of an external timebase strobe. With a 100 µs strobe, the default parameters give about 400 µs in short mode, 50 ms in long mode, and 160 ms from reset to the power-on start request.

Top module: `trig_irq_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `vec_valid` is 0 and `vec_out` is 0. Every filtered pin level starts high, so no edge event is produced while the pins idle high.
- R2: With `long_deb` = 0, a pin's filtered level takes a new raw value only after that value has been seen on SHORT_TICKS consecutive `tick` pulses (default 4). A shorter excursion produces no event.
- R3: With `long_deb` = 1, the hold time is LONG_TICKS `tick` pulses (default 500). An excursion that is long enough in short mode but shorter than this produces no event.
- R4: Enable layout. In `en_lo`, bit 0 enables the falling edge of pin 0, bit 1 the falling edge of pin 1, bit 4 the rising edge of pin 0 and bit 5 the rising edge of pin 1. `en_hi` uses the same bit positions for pins 2 and 3. Bits 2, 3, 6 and 7 of both words are ignored. An edge whose enable bit is 0 is discarded and never becomes pending.
- R5: Vector numbers are as follows. Falling edges: pin 0 → 0, pin 1 → 1, pin 2 → 8, pin 3 → 9. Rising edges: pin 0 → 4, pin 1 → 5, pin 2 → 12, pin 3 → 13. Power-on start → 32. Software jump → 63. No other value is ever presented.
- R6: The power-on start request becomes pending exactly once, on the POI_TICKS-th `tick` after reset is released (default 1600).
- R7: Priority, from highest to lowest: power-on start, pin 0 falling, pin 0 rising, pin 1 falling, pin 1 rising, pin 2 falling, pin 2 rising, pin 3 falling, pin 3 rising, software jump (`jump_req` pulse). Each presentation shows the highest pending source.
- R8: While a vector is presented but not acknowledged, a newly pending source of higher priority is presented at once with a new valid pulse. The displaced source stays pending.
- R9: A presented source stays pending until it is acknowledged. Its valid pulse lasts one cycle and is not repeated while it waits.
- R10: An `ack` while a vector is presented clears that source. The highest remaining pending source is presented two cycles later.
- R11: `vec_out` changes only in a cycle in which `vec_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_n | input | 4 | Raw active-low trigger pins, asynchronous |
| en_lo | input | 8 | Edge enables for pins 0 and 1 |
| en_hi | input | 8 | Edge enables for pins 2 and 3 |
| long_deb | input | 1 | 1 selects the long filter, 0 the short filter |
| tick | input | 1 | Timebase strobe, one cycle wide |
| jump_req | input | 1 | Pulse that makes the software jump pending |
| ack | input | 1 | Retires the presented vector |
| vec_out | output | 6 | Presented vector number |
| vec_valid | output | 1 | One-cycle strobe announcing a new presentation |

## Verification
The checker takes the following for granted about the inputs:
- `tick` is a strobe that counts elapsed filter time.
- `ack` means something only after a valid pulse.
- The enable words may change at any cycle, and an edge is judged against the enable value present in the cycle in which the edge is accepted.

The stimulus keeps within these assumptions:
- It holds `tick` high on every cycle, so filter windows are short, known cycle counts.
- It pulses `ack` for one cycle, and only after it has observed a valid pulse.
- It changes enables only while the pins are still, or a whole filter interval before the edge they are meant to gate.
- It drives the pins asynchronously on the falling clock edge, which the two-stage synchronizer absorbs.

// File: rtl/trig_irq_pkg.sv
package trig_irq_pkg;

    localparam int NPIN = 4;
    localparam int NSRC = 2 * NPIN + 2;
    localparam int SW   = $clog2(NSRC);

    typedef logic [5:0]    vec_t;
    typedef logic [SW-1:0] src_t;

    localparam src_t SRC_START = src_t'(0);
    localparam src_t SRC_JUMP  = src_t'(NSRC - 1);

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    typedef struct packed {
        logic any;
        src_t idx;
    } pick_t;

    // Source index to vector number; index 1+2k is pin k falling, 2+2k pin k rising
    function automatic vec_t src_vector(input src_t s);
        vec_t v;
        case (s)
            4'd0:    v = 6'd32;
            4'd1:    v = 6'd0;
            4'd2:    v = 6'd4;
            4'd3:    v = 6'd1;
            4'd4:    v = 6'd5;
            4'd5:    v = 6'd8;
            4'd6:    v = 6'd12;
            4'd7:    v = 6'd9;
            4'd8:    v = 6'd13;
            default: v = 6'd63;
        endcase
        return v;
    endfunction

    function automatic logic legal_vector(input vec_t v);
        return (v == 6'd0) || (v == 6'd1) || (v == 6'd4) || (v == 6'd5) ||
               (v == 6'd8) || (v == 6'd9) || (v == 6'd12) || (v == 6'd13) ||
               (v == 6'd32) || (v == 6'd63);
    endfunction

    // Lowest set index wins
    function automatic pick_t first_src(input logic [NSRC-1:0] p);
        pick_t r;
        r.any = 1'b0;
        r.idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (p[i]) begin
                r.any = 1'b1;
                r.idx = src_t'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/trig_deb.sv
module trig_deb
    import trig_irq_pkg::*;
#(
    parameter int LONG_TICKS  = 500,
    parameter int SHORT_TICKS = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  pin_raw,
    input  logic  long_sel,
    input  logic  tick,
    output edge_t ev
);
    localparam int CW = $clog2(LONG_TICKS + 1);

    logic          s1, s2, level;
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim = long_sel ? CW'(LONG_TICKS - 1) : CW'(SHORT_TICKS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1    <= 1'b1;
            s2    <= 1'b1;
            level <= 1'b1;
            cnt   <= '0;
            ev    <= '0;
        end else begin
            s1 <= pin_raw;
            s2 <= s1;
            ev <= '0;
            if (s2 == level) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt >= lim) begin
                    level   <= s2;
                    cnt     <= '0;
                    ev.rise <= s2;
                    ev.fall <= ~s2;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/poi_timer.sv
module poi_timer #(
    parameter int POI_TICKS = 1600
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic fire
);
    localparam int CW = $clog2(POI_TICKS + 1);

    logic [CW-1:0] cnt;
    logic          done;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            done <= 1'b0;
            fire <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (!done && tick) begin
                if (cnt == CW'(POI_TICKS - 1)) begin
                    fire <= 1'b1;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/irq_arb.sv
module irq_arb
    import trig_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_req,
    input  logic            ack,
    output vec_t            vec_out,
    output logic            vec_valid,
    output logic [NSRC-1:0] pend_q
);
    logic [NSRC-1:0] clr, pend_d;
    logic            active;
    src_t            cur;
    pick_t           pick;

    always_comb begin
        pick = first_src(pend_q);
        clr  = '0;
        if (ack && active) clr[cur] = 1'b1;
        pend_d = (pend_q & ~clr) | set_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= '0;
            active    <= 1'b0;
            cur       <= '0;
            vec_out   <= '0;
            vec_valid <= 1'b0;
        end else begin
            pend_q    <= pend_d;
            vec_valid <= 1'b0;
            if (ack && active) begin
                active <= 1'b0;
            end else if (pick.any && (!active || pick.idx < cur)) begin
                active    <= 1'b1;
                cur       <= pick.idx;
                vec_out   <= src_vector(pick.idx);
                vec_valid <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/trig_irq_ctrl.sv
module trig_irq_ctrl
    import trig_irq_pkg::*;
#(
    parameter int LONG_TICKS  = 500,
    parameter int SHORT_TICKS = 4,
    parameter int POI_TICKS   = 1600
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] trig_n,
    input  logic [7:0] en_lo,
    input  logic [7:0] en_hi,
    input  logic       long_deb,
    input  logic       tick,
    input  logic       jump_req,
    input  logic       ack,
    output logic [5:0] vec_out,
    output logic       vec_valid
);
    edge_t [NPIN-1:0] ev;
    logic  [NPIN-1:0] en_fall, en_rise;
    logic  [NSRC-1:0] set_req, pend_w;
    logic             start_fire;
    logic             unused_en;

    assign en_fall   = {en_hi[1:0], en_lo[1:0]};
    assign en_rise   = {en_hi[5:4], en_lo[5:4]};
    assign unused_en = ^{en_lo[7:6], en_lo[3:2], en_hi[7:6], en_hi[3:2]};

    for (genvar k = 0; k < NPIN; k++) begin : g_pin
        trig_deb #(
            .LONG_TICKS (LONG_TICKS),
            .SHORT_TICKS(SHORT_TICKS)
        ) u_deb (
            .clk     (clk),
            .rst     (rst),
            .pin_raw (trig_n[k]),
            .long_sel(long_deb),
            .tick    (tick),
            .ev      (ev[k])
        );
        assign set_req[1 + 2*k] = ev[k].fall & en_fall[k];
        assign set_req[2 + 2*k] = ev[k].rise & en_rise[k];
    end

    poi_timer #(.POI_TICKS(POI_TICKS)) u_poi (
        .clk (clk),
        .rst (rst),
        .tick(tick),
        .fire(start_fire)
    );

    assign set_req[SRC_START] = start_fire;
    assign set_req[SRC_JUMP]  = jump_req;

    irq_arb u_arb (
        .clk      (clk),
        .rst      (rst),
        .set_req  (set_req),
        .ack      (ack),
        .vec_out  (vec_out),
        .vec_valid(vec_valid),
        .pend_q   (pend_w)
    );

endmodule

// File: rtl/trig_irq_chk.sv
module trig_irq_chk
    import trig_irq_pkg::*;
#(
    parameter int POI_TICKS = 1600
) (
    input logic            clk,
    input logic            rst,
    input logic            tick,
    input logic [7:0]      en_lo,
    input logic [7:0]      en_hi,
    input logic [5:0]      vec_out,
    input logic            vec_valid,
    input logic [NSRC-1:0] pend
);
    logic [31:0] tcnt;

    always_ff @(posedge clk) begin
        if (rst) tcnt <= '0;
        else if (tick && tcnt != 32'hFFFF_FFFF) tcnt <= tcnt + 1;
    end

    // R5
    legal_vec_chk: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> legal_vector(vec_out));

    // R11
    hold_vec_chk: assert property (@(posedge clk) disable iff (rst)
        !vec_valid |-> $stable(vec_out));

    // R6
    poi_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && vec_out == 6'd32) |-> (tcnt >= 32'(POI_TICKS)));

    // R7
    prio_pick_chk: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (vec_out == src_vector(first_src($past(pend)).idx)));

    // R4
    en_p0f_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend[1]) |-> $past(en_lo[0]));

    // R4
    en_p0r_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend[2]) |-> $past(en_lo[4]));

    // R4
    en_p2f_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend[5]) |-> $past(en_hi[0]));

    // R4
    en_p3r_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend[8]) |-> $past(en_hi[5]));

endmodule

bind trig_irq_ctrl trig_irq_chk #(.POI_TICKS(POI_TICKS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .en_lo    (en_lo),
    .en_hi    (en_hi),
    .vec_out  (vec_out),
    .vec_valid(vec_valid),
    .pend     (pend_w)
);

// File: tb/trig_irq_ctrl_test.sv
module trig_irq_ctrl_test;

    localparam int LONG_T  = 40;
    localparam int SHORT_T = 4;
    localparam int POI_T   = 120;
    localparam int WIN     = 30;
    localparam int WDOG    = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] trig_n = 4'hF;
    logic [7:0] en_lo = '0, en_hi = '0;
    logic       long_deb = 1'b0, tick = 1'b1, jump_req = 1'b0, ack = 1'b0;
    logic [5:0] vec_out;
    logic       vec_valid;

    int errors = 0, checks = 0, cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    trig_irq_ctrl #(
        .LONG_TICKS(LONG_T), .SHORT_TICKS(SHORT_T), .POI_TICKS(POI_T)
    ) uut (
        .clk(clk), .rst(rst), .trig_n(trig_n), .en_lo(en_lo), .en_hi(en_hi),
        .long_deb(long_deb), .tick(tick), .jump_req(jump_req), .ack(ack),
        .vec_out(vec_out), .vec_valid(vec_valid)
    );

    // {pin[1:0], level, en_lo[7:0], en_hi[7:0], expect, vec[5:0]}
    localparam logic [25:0] STEPS [12] = '{
        {2'd0, 1'b0, 8'h01, 8'h00, 1'b1, 6'd0},   // R4 R5 pin0 fall
        {2'd0, 1'b1, 8'h10, 8'h00, 1'b1, 6'd4},   // pin0 rise
        {2'd1, 1'b0, 8'h02, 8'h00, 1'b1, 6'd1},   // pin1 fall
        {2'd1, 1'b1, 8'h20, 8'h00, 1'b1, 6'd5},   // pin1 rise
        {2'd2, 1'b0, 8'h00, 8'h01, 1'b1, 6'd8},   // pin2 fall
        {2'd2, 1'b1, 8'h00, 8'h10, 1'b1, 6'd12},  // pin2 rise
        {2'd3, 1'b0, 8'h00, 8'h02, 1'b1, 6'd9},   // pin3 fall
        {2'd3, 1'b1, 8'h00, 8'h20, 1'b1, 6'd13},  // pin3 rise
        {2'd0, 1'b0, 8'h10, 8'h00, 1'b0, 6'd0},   // fall disabled
        {2'd0, 1'b1, 8'h10, 8'h00, 1'b1, 6'd4},
        {2'd1, 1'b0, 8'hCC, 8'hCC, 1'b0, 6'd0},   // ignored bits only
        {2'd1, 1'b1, 8'hCC, 8'hCC, 1'b0, 6'd0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_vec(input int tmo, output bit got, output logic [5:0] v, output int n);
        got = 0; v = '0; n = 0;
        for (int i = 0; i < tmo; i++) begin
            @(negedge clk);
            n++;
            if (vec_valid) begin
                got = 1; v = vec_out;
                break;
            end
        end
    endtask

    task automatic do_ack();
        @(negedge clk) ack = 1'b1;
        @(negedge clk) ack = 1'b0;
    endtask

    task automatic expect_vec(input int tmo, input logic [5:0] ev, input string req);
        bit got; logic [5:0] v; int n;
        wait_vec(tmo, got, v, n);
        check(got && v == ev, req, got ? int'(v) : -1, int'(ev));
    endtask

    task automatic expect_none(input int tmo, input string req);
        bit got; logic [5:0] v; int n;
        wait_vec(tmo, got, v, n);
        check(!got, req, got ? int'(v) : -1, -1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG && !done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WDOG);
            finish_run();
        end
    end

    initial begin
        bit got; logic [5:0] v; int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(vec_valid == 1'b0, "R1", int'(vec_valid), 0);
        check(vec_out == 6'd0, "R1", int'(vec_out), 0);
        rst = 1'b0;
        @(negedge clk);
        check(vec_valid == 1'b0 && vec_out == 6'd0, "R1", int'(vec_out), 0);

        // R6 start request timing
        wait_vec(POI_T + 20, got, v, n);
        check(got && v == 6'd32, "R6", got ? int'(v) : -1, 32);
        check(n + 1 >= POI_T && n + 1 <= POI_T + 4, "R6", n + 1, POI_T + 1);
        do_ack();
        expect_none(POI_T + 20, "R6");

        // table walk: R2 R4 R5 R10
        for (int s = 0; s < 12; s++) begin
            logic [25:0] e;
            e = STEPS[s];
            @(negedge clk);
            en_lo = e[22:15];
            en_hi = e[14:7];
            trig_n[e[25:24]] = e[23];
            if (e[6]) begin
                expect_vec(WIN, e[5:0], "R5");
                do_ack();
            end else begin
                expect_none(WIN, "R4");
            end
        end

        // R2 glitch shorter than filter
        @(negedge clk);
        en_lo = 8'h11; en_hi = 8'h00;
        trig_n[0] = 1'b0;
        repeat (2) @(negedge clk);
        trig_n[0] = 1'b1;
        expect_none(WIN, "R2");

        // R3 long filter
        long_deb = 1'b1; en_lo = 8'h01;
        trig_n[0] = 1'b0;
        expect_none(WIN, "R3");
        expect_vec(LONG_T + 20, 6'd0, "R3");
        do_ack();
        trig_n[0] = 1'b1;
        expect_none(LONG_T + 20, "R4");
        long_deb = 1'b0;

        // R7 R8 R9 R10 priority and preemption
        @(negedge clk);
        en_lo = 8'h01; en_hi = 8'h02;
        jump_req = 1'b1;
        @(negedge clk);
        jump_req = 1'b0;
        trig_n[0] = 1'b0; trig_n[3] = 1'b0;
        expect_vec(5, 6'd63, "R7");
        expect_vec(WIN, 6'd0, "R8");
        expect_none(40, "R9");
        do_ack();
        expect_vec(5, 6'd9, "R10");
        do_ack();
        expect_vec(5, 6'd63, "R7");
        do_ack();
        expect_none(WIN, "R10");

        en_lo = 8'h00; en_hi = 8'h00;
        trig_n = 4'hF;
        expect_none(WIN, "R4");
        finish_run();
    end

endmodule